// File: doc/BRIEF.md
# Audio Frame Sequencer

This block paces the slow housekeeping of a sound generator. It advances once per CPU cycle and divides that clock down into steps. Each step can send a quarter-frame strobe to the envelope units and a half-frame strobe to the length and sweep units. A four-step pattern and a five-step pattern are available. The four-step pattern also raises a frame interrupt flag once per frame, unless the interrupt is inhibited.

Software reaches the block through a single control byte, written with a one-cycle strobe. The byte picks the pattern and the interrupt inhibit, and it restarts the sequence. A separate clear input lets the status-read logic drop the interrupt flag.

Top module: `frame_seq_top`

## Requirements
- R1: Synchronous reset (`rst` high) drives both strobes and `frame_irq` low and selects four-step mode with the inhibit cleared. The first step fires 7457 cycles after the last reset edge: the strobes are visible after clock edge R+7457.
- R2: After a step fires, the divider reloads to 7456 and counts down, so the following step fires 7457 cycles later.
- R3: In four-step mode, steps 0 through 3 each emit `quarter_strobe`. Steps 1 and 3 also emit `half_strobe`. After step 3 the index returns to 0.
- R4: In four-step mode, step 3 sets `frame_irq` when the inhibit is clear. The flag stays high until it is cleared. While the inhibit is set, the flag never rises.
- R5: In five-step mode, steps 0, 1, 2 and 4 emit `quarter_strobe`, steps 1 and 4 emit `half_strobe`, and step 3 emits nothing. The index wraps after step 4, and `frame_irq` never rises.
- R6: On a control write, `ctrl_data[7]`=1 selects five-step mode (0 selects four-step) and `ctrl_data[6]`=1 sets the inhibit. A write with bit 6 set lowers `frame_irq` on the next cycle.
- R7: A control write resets the step index to 0 and loads the divider with 7464. The next step (step 0) therefore fires 7465 cycles after the write edge.
- R8: A write that selects five-step mode emits `quarter_strobe` and `half_strobe` together in the cycle after the write. A write that selects four-step mode emits neither.
- R9: A pulse on `irq_clr` lowers `frame_irq` on the next cycle.
- R10: When a control write lands on the same edge as a natural step, the write wins. That step emits no strobe and no flag, and timing restarts as in R7.
- R11: Each strobe is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | One-cycle control write strobe |
| ctrl_data | input | 8 | Control byte: bit 7 selects five-step mode, bit 6 sets the inhibit |
| irq_clr | input | 1 | Clears the frame interrupt flag |
| quarter_strobe | output | 1 | Quarter-frame pulse |
| half_strobe | output | 1 | Half-frame pulse |
| frame_irq | output | 1 | Frame interrupt flag |

## Verification
The bench aims at the following corner cases, with the fault each one exposes:
- Exact step timing from reset and after a write. A design that is off by one in the divider, or that forgets the eight extra cycles after a write, puts every strobe on the wrong cycle.
- The silent step 3 in five-step mode and the strobe pair fired by a write that selects five-step mode. A design that copies the four-step pattern, or skips the immediate pair, produces a strobe stream that no longer matches.
- The inhibit both clearing a pending flag and suppressing the next one. A design that only blocks new flags leaves the interrupt stuck high.
- A write placed exactly on a natural step edge. A design that gives the step priority emits a spurious strobe and keeps the old timing.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    localparam int unsigned FS_DIV_RELOAD  = 7456;
    localparam int unsigned FS_WRITE_EXTRA = 8;

    typedef enum logic {
        SEQ_FOUR = 1'b0,
        SEQ_FIVE = 1'b1
    } seq_mode_e;

    typedef struct packed {
        seq_mode_e mode;
        logic      inhibit;
    } ctrl_t;

    typedef struct packed {
        logic quarter;
        logic half;
        logic irq_set;
    } step_act_t;

    function automatic ctrl_t decode_ctrl(input logic [7:0] d);
        ctrl_t c;
        c.mode    = seq_mode_e'(d[7]);
        c.inhibit = d[6];
        return c;
    endfunction

    function automatic step_act_t step_actions(input seq_mode_e m, input logic [2:0] s);
        step_act_t a;
        a = '0;
        if (m == SEQ_FOUR) begin
            a.quarter = 1'b1;
            a.half    = (s == 3'd1) || (s == 3'd3);
            a.irq_set = (s == 3'd3);
        end else begin
            a.quarter = (s != 3'd3);
            a.half    = (s == 3'd1) || (s == 3'd4);
        end
        return a;
    endfunction

    function automatic logic [2:0] next_step(input seq_mode_e m, input logic [2:0] s);
        logic [2:0] last;
        last = (m == SEQ_FOUR) ? 3'd3 : 3'd4;
        return (s >= last) ? 3'd0 : s + 3'd1;
    endfunction

endpackage

// File: rtl/frame_seq_divider.sv
module frame_seq_divider #(
    parameter int unsigned W       = 13,
    parameter int unsigned RELOAD  = 7456,
    parameter int unsigned WR_LOAD = 7464
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    output logic         tick,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RELOAD);
        else if (wr)
            cnt_q <= W'(WR_LOAD);
        else if (cnt_q == '0)
            cnt_q <= W'(RELOAD);
        else
            cnt_q <= cnt_q - 1'b1;
    end

    assign tick  = (cnt_q == '0) && !wr;
    assign count = cnt_q;

    // R2
    reload_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count == W'(RELOAD)));

endmodule

// File: rtl/frame_seq_steps.sv
module frame_seq_steps
    import frame_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  ctrl_t     wr_ctrl,
    input  logic      tick,
    output logic      quarter_o,
    output logic      half_o,
    output logic      irq_set_o,
    output seq_mode_e mode_o
);

    seq_mode_e  mode_q;
    logic [2:0] step_q;
    step_act_t  act;

    assign act = step_actions(mode_q, step_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= SEQ_FOUR;
            step_q    <= 3'd0;
            quarter_o <= 1'b0;
            half_o    <= 1'b0;
        end else begin
            quarter_o <= 1'b0;
            half_o    <= 1'b0;
            if (wr) begin
                mode_q <= wr_ctrl.mode;
                step_q <= 3'd0;
                if (wr_ctrl.mode == SEQ_FIVE) begin
                    quarter_o <= 1'b1;
                    half_o    <= 1'b1;
                end
            end else if (tick) begin
                quarter_o <= act.quarter;
                half_o    <= act.half;
                step_q    <= next_step(mode_q, step_q);
            end
        end
    end

    assign irq_set_o = tick && !wr && act.irq_set;
    assign mode_o    = mode_q;

    // R11
    quarter_single_chk: assert property (@(posedge clk) disable iff (rst)
        quarter_o |=> !quarter_o);

    // R11
    half_single_chk: assert property (@(posedge clk) disable iff (rst)
        half_o |=> !half_o);

    // R7
    step_restart_chk: assert property (@(posedge clk) disable iff (rst)
        wr |=> (step_q == 3'd0));

endmodule

// File: rtl/frame_seq_irq.sv
module frame_seq_irq (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wr_inhibit,
    input  logic set_req,
    input  logic clr,
    output logic irq
);

    logic inhibit_q;
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            inhibit_q <= 1'b0;
            flag_q    <= 1'b0;
        end else begin
            if (wr)
                inhibit_q <= wr_inhibit;
            if (clr || (wr && wr_inhibit))
                flag_q <= 1'b0;
            else if (set_req && !inhibit_q)
                flag_q <= 1'b1;
        end
    end

    assign irq = flag_q;

    // R9
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !irq);

    // R6
    inhibit_write_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && wr_inhibit) |=> !irq);

    // R4
    inhibit_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !$past(inhibit_q));

endmodule

// File: rtl/frame_seq_top.sv
module frame_seq_top
    import frame_seq_pkg::*;
#(
    parameter int unsigned DIV_RELOAD  = FS_DIV_RELOAD,
    parameter int unsigned WRITE_EXTRA = FS_WRITE_EXTRA
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  logic [7:0] ctrl_data,
    input  logic       irq_clr,
    output logic       quarter_strobe,
    output logic       half_strobe,
    output logic       frame_irq
);

    localparam int unsigned WR_LOAD = DIV_RELOAD + WRITE_EXTRA;
    localparam int unsigned CNT_W   = $clog2(WR_LOAD + 1);

    ctrl_t             wr_ctrl;
    logic              tick;
    logic [CNT_W-1:0]  div_count;
    logic              irq_set;
    seq_mode_e         mode;

    assign wr_ctrl = decode_ctrl(ctrl_data);

    frame_seq_divider #(
        .W       (CNT_W),
        .RELOAD  (DIV_RELOAD),
        .WR_LOAD (WR_LOAD)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctrl_wr),
        .tick  (tick),
        .count (div_count)
    );

    frame_seq_steps u_steps (
        .clk       (clk),
        .rst       (rst),
        .wr        (ctrl_wr),
        .wr_ctrl   (wr_ctrl),
        .tick      (tick),
        .quarter_o (quarter_strobe),
        .half_o    (half_strobe),
        .irq_set_o (irq_set),
        .mode_o    (mode)
    );

    frame_seq_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .wr         (ctrl_wr),
        .wr_inhibit (wr_ctrl.inhibit),
        .set_req    (irq_set),
        .clr        (irq_clr),
        .irq        (frame_irq)
    );

    // R7 and R10
    write_reload_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (div_count == CNT_W'(WR_LOAD)));

    // R8
    five_write_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ctrl_data[7]) |=> (quarter_strobe && half_strobe));

    // R8
    four_write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_data[7]) |=> (!quarter_strobe && !half_strobe));

    // R5
    five_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == SEQ_FIVE) |-> !$rose(frame_irq));

endmodule

// File: tb/frame_seq_top_tb.sv
module frame_seq_top_tb;

    localparam int PER1 = 7457;
    localparam int PERW = 7465;

    typedef struct {
        int    cyc;
        bit    q;
        bit    h;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_data = 8'h00;
    logic       irq_clr = 1'b0;
    logic       quarter_strobe;
    logic       half_strobe;
    logic       frame_irq;

    int  cyc = 0;
    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    exp_t exq[$];

    frame_seq_top u_dut (
        .clk            (clk),
        .rst            (rst),
        .ctrl_wr        (ctrl_wr),
        .ctrl_data      (ctrl_data),
        .irq_clr        (irq_clr),
        .quarter_strobe (quarter_strobe),
        .half_strobe    (half_strobe),
        .frame_irq      (frame_irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // monitor: every strobe must match the next expected item
    always @(negedge clk) begin
        if (!rst && !done && (quarter_strobe || half_strobe)) begin
            if (exq.size() == 0) begin
                check(1'b0, "R11 unexpected strobe", {quarter_strobe, half_strobe}, 0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                check(e.cyc == cyc, e.req, cyc, e.cyc);
                check({quarter_strobe, half_strobe} == {e.q, e.h}, e.req,
                      {quarter_strobe, half_strobe}, {e.q, e.h});
            end
        end
    end

    function automatic void push(input int c, input bit q, input bit h, input string req);
        exp_t e;
        if (!q && !h) return;
        e.cyc = c; e.q = q; e.h = h; e.req = req;
        exq.push_back(e);
    endfunction

    // expected strobes for n steps, first at first_cyc, pattern from the requirements
    function automatic void push_steps(input int first_cyc, input bit five, input int n);
        for (int k = 0; k < n; k++) begin
            int s;
            s = five ? (k % 5) : (k % 4);
            if (five)
                push(first_cyc + PER1 * k, s != 3, (s == 1) || (s == 4), "R2/R5 five-step strobe");
            else
                push(first_cyc + PER1 * k, 1'b1, (s == 1) || (s == 3), "R2/R3 four-step strobe");
        end
    endfunction

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // drive a write sampled at edge cyc+1; returns that edge number
    task automatic do_write(input logic [7:0] d, output int e);
        ctrl_wr   = 1'b1;
        ctrl_data = d;
        e = cyc + 1;
        if (d[7]) push(e, 1'b1, 1'b1, "R8 write pair");
        push_steps(e + PERW, d[7], d[7] ? 5 : 4);
        @(negedge clk);
        ctrl_wr   = 1'b0;
        ctrl_data = 8'h00;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int r, e1, e2, e3, e4, nat;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        r = cyc;
        // R1 reset state
        check(quarter_strobe == 1'b0, "R1 quarter after reset", quarter_strobe, 0);
        check(half_strobe == 1'b0, "R1 half after reset", half_strobe, 0);
        check(frame_irq == 1'b0, "R1 irq after reset", frame_irq, 0);
        // R1/R3 four-step frame from reset
        push_steps(r + PER1, 1'b0, 4);
        wait_to(r + PER1 * 3);
        check(frame_irq == 1'b0, "R4 irq before step 3", frame_irq, 0);
        wait_to(r + PER1 * 4);
        check(frame_irq == 1'b1, "R4 irq at step 3", frame_irq, 1);
        wait_to(r + PER1 * 4 + 10);
        check(frame_irq == 1'b1, "R4 irq held", frame_irq, 1);
        // R9 clear
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(frame_irq == 1'b0, "R9 irq cleared", frame_irq, 0);
        // R5/R7/R8 five-step mode
        do_write(8'h80, e1);
        check(frame_irq == 1'b0, "R6 irq low after five write", frame_irq, 0);
        wait_to(e1 + PERW + PER1 * 4 + 5);
        check(frame_irq == 1'b0, "R5 no irq in five-step", frame_irq, 0);
        // back to four-step, no immediate strobe (R8)
        do_write(8'h00, e2);
        wait_to(e2 + PERW + PER1 * 3);
        check(frame_irq == 1'b1, "R4 irq after write to four-step", frame_irq, 1);
        // R6 inhibit clears pending flag
        @(negedge clk);
        do_write(8'h40, e3);
        check(frame_irq == 1'b0, "R6 inhibit clears irq", frame_irq, 0);
        wait_to(e3 + PERW + PER1 * 3 + 2);
        check(frame_irq == 1'b0, "R4 inhibit blocks irq", frame_irq, 0);
        // R10 write on the natural step edge
        nat = e3 + PERW + PER1 * 4;
        wait_to(nat - 1);
        ctrl_wr   = 1'b1;
        ctrl_data = 8'h40;
        e4 = cyc + 1;
        check(e4 == nat, "R10 write aligned with step", e4, nat);
        push(e4 + PERW, 1'b1, 1'b0, "R10/R7 step 0 after colliding write");
        @(negedge clk);
        ctrl_wr   = 1'b0;
        ctrl_data = 8'h00;
        wait_to(e4 + PERW + 3);
        check(exq.size() == 0, "R10 all expected strobes seen", exq.size(), 0);
        check(frame_irq == 1'b0, "R10 no irq from colliding step", frame_irq, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule